// File: doc/BRIEF.md
# Full-Duplex Serial ADC Command Front End

This block sits between an 8-bit register bus and a serial analog-to-digital converter whose link carries data both ways at once. Software writes a command byte. The block then runs one serial frame. During that frame the command goes out on the data-out line, most significant bit first. In the same frame the converter's 16-bit result comes back on the data-in line. When the frame ends, the result is latched into two byte registers, a ready flag is raised and a one-cycle conversion-start strobe tells the converter to begin converting the new command.

Each frame carries a new command out and the result of the previous conversion back. So the data read after a command always belongs to the command written before it. The first frame after reset, or after any change of channel or range, returns stale data, and software must throw it away as a flush. For bipolar ranges the converter's result is two's complement. The block passes it through unchanged and does no sign conversion.

The serial clock is derived from the system clock. The parameter `HALF_DIV` gives the number of system clocks in each half period of the serial clock.

Top module: `sadc_cmd_frontend`

## Requirements
- R1: After reset, all four registers read zero, `irq` is low, and `adc_sclk`, `adc_mosi` and `adc_convst` are low.
- R2: A write to the command register (offset 2) while idle starts a frame. From the next cycle, status bit 6 (busy) reads 1 and status bit 7 (data ready) reads 0.
- R3: During a frame, `adc_mosi` carries the accepted command byte, most significant bit first. A new bit is launched only on a falling edge of `adc_sclk`, so `adc_mosi` stays stable while `adc_sclk` is high.
- R4: `adc_miso` is sampled on each rising edge of `adc_sclk`, most significant bit first, for 16 bits. The low byte then reads at offset 0 and the high byte reads at offset 1.
- R5: The result returned by a frame is the word the converter presented, which belongs to the previous command. The first frame after reset returns the converter's power-up word.
- R6: Data ready (status bit 7) and a one-cycle `adc_convst` pulse appear together, on the cycle after the sixteenth falling edge of `adc_sclk`. Data ready rises only after a complete frame.
- R7: A command write while busy is ignored. It does not change the frame in flight, the command register or data ready, and it sets sticky status bit 1 (overrun). A write in the very cycle the frame ends counts as busy. Writing the status register with bit 1 set clears overrun.
- R8: Status bit 4 (interrupt pending) sets together with data ready and clears when a command is accepted. Status bit 0 is an enable written through offset 3, and `irq` equals pending AND enable.
- R9: Each half period of `adc_sclk` lasts `HALF_DIV` system clocks, so a frame lasts 32·`HALF_DIV` cycles from the write to data ready.
- R10: The command byte holds single-ended select in bit 7, odd-channel select in bit 6, channel pair in bits 5:4 and range code in bits 3:2. Bits 1:0 are forced to zero, both in the register that reads back at offset 2 and on the wire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| adc_sclk | output | 1 | Serial clock to the converter, idles low |
| adc_mosi | output | 1 | Command bits to the converter |
| adc_miso | input | 1 | Result bits from the converter |
| adc_convst | output | 1 | One-cycle conversion-start strobe |
| irq | output | 1 | Interrupt request |

## Verification
The two functions that can fall in the same cycle are the end of a frame and a new command write. The bench places a command write on exactly the edge where the sixteenth falling serial edge ends the frame. At that edge the result is latched and data ready rises while the write is judged. The bench then expects the result of the finished frame, data ready still high, overrun set, the command register unchanged and no new frame on the serial lines. A write earlier in the frame is also checked as ignored: the result of the next frame must belong to the original command.

// File: rtl/sadc_fe_pkg.sv
package sadc_fe_pkg;

    localparam int BUS_W = 8;
    localparam int RES_W = 16;

    localparam logic [1:0] OFS_RES_LO = 2'd0;
    localparam logic [1:0] OFS_RES_HI = 2'd1;
    localparam logic [1:0] OFS_CMD    = 2'd2;
    localparam logic [1:0] OFS_STATUS = 2'd3;

    // Command byte fields, the converter decodes these positions.
    typedef struct packed {
        logic       single_ended;
        logic       odd_chan;
        logic [1:0] chan_pair;
        logic [1:0] span;
        logic [1:0] unused;
    } conv_cmd_t;

    typedef struct packed {
        logic data_ready;
        logic busy;
        logic rsv5;
        logic irq_pend;
        logic rsv3;
        logic rsv2;
        logic overrun;
        logic irq_en;
    } stat_t;

    function automatic conv_cmd_t decode_cmd(input logic [BUS_W-1:0] raw);
        conv_cmd_t c;
        c = conv_cmd_t'(raw);
        c.unused = 2'b00;
        return c;
    endfunction

    function automatic logic [BUS_W-1:0] pack_status(input logic rdy, input logic bsy,
                                                     input logic pend, input logic ovr,
                                                     input logic en);
        stat_t s;
        s = '0;
        s.data_ready = rdy;
        s.busy       = bsy;
        s.irq_pend   = pend;
        s.overrun    = ovr;
        s.irq_en     = en;
        return s;
    endfunction

endpackage

// File: rtl/sadc_serial_engine.sv
module sadc_serial_engine #(
    parameter int HALF_DIV   = 4,
    parameter int FRAME_BITS = 16,
    parameter int CMD_BITS   = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [CMD_BITS-1:0]   cmd_byte,
    output logic                  busy,
    output logic                  frame_done,
    output logic [FRAME_BITS-1:0] rx_word,
    output logic                  sclk,
    output logic                  mosi,
    input  logic                  miso
);
    localparam int DIV_W = $clog2(HALF_DIV + 1);
    localparam int BIT_W = $clog2(FRAME_BITS);
    localparam int PAD   = FRAME_BITS - CMD_BITS;

    logic [DIV_W-1:0]      div_cnt;
    logic [BIT_W-1:0]      bit_cnt;
    logic [FRAME_BITS-1:0] tx_sr;
    logic [FRAME_BITS-1:0] rx_sr;
    logic                  half_tick;
    logic                  last_bit;

    assign half_tick  = busy && (div_cnt == DIV_W'(HALF_DIV - 1));
    assign last_bit   = (bit_cnt == BIT_W'(FRAME_BITS - 1));
    assign frame_done = half_tick && sclk && last_bit;
    assign mosi       = busy && tx_sr[FRAME_BITS-1];
    assign rx_word    = rx_sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            sclk    <= 1'b0;
            div_cnt <= '0;
            bit_cnt <= '0;
            tx_sr   <= '0;
            rx_sr   <= '0;
        end else if (!busy) begin
            div_cnt <= '0;
            if (start) begin
                busy    <= 1'b1;
                sclk    <= 1'b0;
                bit_cnt <= '0;
                tx_sr   <= FRAME_BITS'(cmd_byte) << PAD;
            end
        end else begin
            div_cnt <= half_tick ? '0 : div_cnt + DIV_W'(1);
            if (half_tick) begin
                if (!sclk) begin
                    // rising edge: capture the converter's bit
                    sclk  <= 1'b1;
                    rx_sr <= {rx_sr[FRAME_BITS-2:0], miso};
                end else begin
                    // falling edge: launch the next command bit
                    sclk <= 1'b0;
                    if (last_bit) begin
                        busy <= 1'b0;
                    end else begin
                        bit_cnt <= bit_cnt + BIT_W'(1);
                        tx_sr   <= {tx_sr[FRAME_BITS-2:0], 1'b0};
                    end
                end
            end
        end
    end

    // R3: the data line only moves while the serial clock is low
    a_r3_mosi_hold: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(mosi));

    // R9: serial clock parks low between frames
    a_r9_idle_sclk_low: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sclk);

endmodule

// File: rtl/sadc_reg_bank.sv
module sadc_reg_bank
    import sadc_fe_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [1:0]       addr,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata,
    input  logic             eng_busy,
    input  logic             eng_done,
    input  logic [RES_W-1:0] eng_word,
    output logic             eng_start,
    output logic [BUS_W-1:0] eng_cmd,
    output logic             convst,
    output logic             irq
);
    conv_cmd_t        cmd_q;
    conv_cmd_t        cmd_next;
    logic [BUS_W-1:0] lo_q;
    logic [BUS_W-1:0] hi_q;
    logic             ready_q;
    logic             pend_q;
    logic             en_q;
    logic             ovr_q;
    logic             convst_q;
    logic             cmd_wr;
    logic             stat_wr;

    assign cmd_wr    = we && (addr == OFS_CMD);
    assign stat_wr   = we && (addr == OFS_STATUS);
    assign cmd_next  = decode_cmd(wdata);
    assign eng_start = cmd_wr && !eng_busy;
    assign eng_cmd   = cmd_next;
    assign convst    = convst_q;
    assign irq       = pend_q && en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q    <= '0;
            lo_q     <= '0;
            hi_q     <= '0;
            ready_q  <= 1'b0;
            pend_q   <= 1'b0;
            en_q     <= 1'b0;
            ovr_q    <= 1'b0;
            convst_q <= 1'b0;
        end else begin
            convst_q <= eng_done;
            if (eng_done) begin
                lo_q    <= eng_word[BUS_W-1:0];
                hi_q    <= eng_word[RES_W-1:BUS_W];
                ready_q <= 1'b1;
                pend_q  <= 1'b1;
            end
            if (eng_start) begin
                cmd_q   <= cmd_next;
                ready_q <= 1'b0;
                pend_q  <= 1'b0;
            end
            if (stat_wr) begin
                en_q <= wdata[0];
                if (wdata[1]) ovr_q <= 1'b0;
            end
            if (cmd_wr && eng_busy) ovr_q <= 1'b1;
        end
    end

    always_comb begin
        unique case (addr)
            OFS_RES_LO: rdata = lo_q;
            OFS_RES_HI: rdata = hi_q;
            OFS_CMD:    rdata = cmd_q;
            default:    rdata = pack_status(ready_q, eng_busy, pend_q, ovr_q, en_q);
        endcase
    end

    // R6: ready only follows a finished frame
    a_r6_ready_from_frame: assert property (@(posedge clk) disable iff (rst)
        $rose(ready_q) |-> $past(eng_done));

    // R2: an accepted command drops ready and the engine runs
    a_r2_accept_starts: assert property (@(posedge clk) disable iff (rst)
        eng_start |=> (!ready_q && eng_busy));

    // R7: overrun stays until explicitly cleared
    a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovr_q && !(stat_wr && wdata[1])) |=> ovr_q);

    // R8: pending never outlives ready
    a_r8_pend_with_ready: assert property (@(posedge clk) disable iff (rst)
        pend_q |-> ready_q);

endmodule

// File: rtl/sadc_cmd_frontend.sv
module sadc_cmd_frontend
    import sadc_fe_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_we,
    input  logic [1:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    output logic             adc_sclk,
    output logic             adc_mosi,
    input  logic             adc_miso,
    output logic             adc_convst,
    output logic             irq
);
    logic             busy;
    logic             done;
    logic             start;
    logic [RES_W-1:0] word;
    logic [BUS_W-1:0] cmd;

    sadc_reg_bank u_regs (
        .clk       (clk),
        .rst       (rst),
        .we        (bus_we),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .rdata     (bus_rdata),
        .eng_busy  (busy),
        .eng_done  (done),
        .eng_word  (word),
        .eng_start (start),
        .eng_cmd   (cmd),
        .convst    (adc_convst),
        .irq       (irq)
    );

    sadc_serial_engine #(
        .HALF_DIV   (HALF_DIV),
        .FRAME_BITS (RES_W),
        .CMD_BITS   (BUS_W)
    ) u_engine (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .cmd_byte   (cmd),
        .busy       (busy),
        .frame_done (done),
        .rx_word    (word),
        .sclk       (adc_sclk),
        .mosi       (adc_mosi),
        .miso       (adc_miso)
    );

endmodule

// File: tb/sadc_cmd_frontend_tb_top.sv
module sadc_cmd_frontend_tb_top;
    localparam int HALF = 4;
    localparam int FRAME_CYC = 32 * HALF;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       adc_sclk, adc_mosi, adc_miso, adc_convst, irq;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    int wr_cyc = 0;
    int n_done = 0;
    int exp_n = 0;
    logic [15:0] prev_exp = 16'hA5C3;
    logic [7:0]  q_cmd[$];
    logic [15:0] q_res[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sadc_cmd_frontend #(.HALF_DIV(HALF)) dut_i (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .adc_sclk(adc_sclk),
        .adc_mosi(adc_mosi), .adc_miso(adc_miso), .adc_convst(adc_convst), .irq(irq)
    );

    // converter model: answers the previous command
    function automatic logic [15:0] conv_model(input logic [7:0] c);
        return {~c, c ^ 8'h96};
    endfunction

    logic [15:0] adc_sr;
    logic [7:0]  cap;
    int          cap_n;
    logic        sclk_prev;
    assign adc_miso = adc_sr[15];

    always @(negedge clk) begin
        if (rst) begin
            adc_sr <= 16'hA5C3; cap <= 8'd0; cap_n <= 0; sclk_prev <= 1'b0;
        end else begin
            sclk_prev <= adc_sclk;
            if (adc_convst) begin
                adc_sr <= conv_model(cap);
                cap_n  <= 0;
            end else if (adc_sclk && !sclk_prev) begin
                if (cap_n < 8) begin
                    cap   <= {cap[6:0], adc_mosi};
                    cap_n <= cap_n + 1;
                end
            end else if (!adc_sclk && sclk_prev) begin
                adc_sr <= {adc_sr[14:0], 1'b0};
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk); bus_we = 1'b0;
    endtask

    task automatic wait_done();
        while (n_done < exp_n) @(negedge clk);
    endtask

    // driver: pushes the expected frame, then writes the command
    task automatic issue(input logic [7:0] c, input bit wait_it);
        logic [7:0] cs;
        logic [7:0] st;
        cs = c & 8'hFC;
        q_cmd.push_back(cs);
        q_res.push_back(prev_exp);
        prev_exp = conv_model(cs);
        exp_n++;
        bus_write(2'd2, c);
        wr_cyc = cyc;
        rd(2'd3, st);
        chk("R2 busy after command", st[6], 1'b1);
        chk("R2 ready cleared", st[7], 1'b0);
        if (wait_it) wait_done();
    endtask

    // monitor: compares each finished frame against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && adc_convst) begin
                logic [7:0] lo, hi, st;
                logic [7:0] ec;
                logic [15:0] er;
                #1 bus_addr = 2'd0;
                #1 lo = bus_rdata; bus_addr = 2'd1;
                #1 hi = bus_rdata; bus_addr = 2'd3;
                #1 st = bus_rdata;
                if (q_res.size() == 0) begin
                    chk("R7 unexpected frame", 1, 0);
                end else begin
                    ec = q_cmd.pop_front();
                    er = q_res.pop_front();
                    chk("R4/R5 result low byte", lo, er[7:0]);
                    chk("R4/R5 result high byte", hi, er[15:8]);
                    chk("R3 command on wire", cap, ec);
                    chk("R9 frame length", cyc - wr_cyc, FRAME_CYC);
                    chk("R6 ready with strobe", st[7], 1'b1);
                end
                n_done++;
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            if (cyc > 100000) begin
                n_err++; n_chk++;
                $display("FAIL watchdog actual=%0d expected=<100000", cyc);
                $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
                $finish;
            end
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd(2'd0, v); chk("R1 low byte", v, 8'h00);
        rd(2'd1, v); chk("R1 high byte", v, 8'h00);
        rd(2'd2, v); chk("R1 command", v, 8'h00);
        rd(2'd3, v); chk("R1 status", v, 8'h00);
        chk("R1 idle lines", {adc_sclk, adc_mosi, adc_convst, irq}, 4'b0000);

        // R5 flush frame, then R8 interrupt gating
        issue(8'h9C, 1'b1);
        rd(2'd3, v); chk("R8 pending set", v[4], 1'b1);
        chk("R8 irq masked", irq, 1'b0);
        bus_write(2'd3, 8'h01);
        #1 chk("R8 irq enabled", irq, 1'b1);

        // R10 reserved bits forced to zero
        issue(8'h7F, 1'b0);
        chk("R8 irq cleared by command", irq, 1'b0);
        rd(2'd2, v); chk("R10 command readback", v, 8'h7C);
        wait_done();

        // R7 write in mid-frame is ignored
        issue(8'h44, 1'b0);
        repeat (10) @(negedge clk);
        bus_write(2'd2, 8'hFF);
        rd(2'd3, v); chk("R7 overrun set", v[1], 1'b1);
        rd(2'd2, v); chk("R7 command kept", v, 8'h44);
        wait_done();
        issue(8'h10, 1'b1);
        bus_write(2'd3, 8'h03);
        rd(2'd3, v); chk("R7 overrun cleared", v[1], 1'b0);
        chk("R8 enable kept", v[0], 1'b1);

        // R7 write on the exact closing edge of a frame
        issue(8'h28, 1'b0);
        repeat (FRAME_CYC - 2) @(negedge clk);
        bus_write(2'd2, 8'hEC);
        wait_done();
        rd(2'd3, v);
        chk("R7 ready kept on collision", v[7], 1'b1);
        chk("R7 overrun on collision", v[1], 1'b1);
        chk("R7 no new frame", v[6], 1'b0);
        rd(2'd2, v); chk("R7 command kept on collision", v, 8'h28);
        repeat (3 * HALF) @(negedge clk);
        chk("R7 serial clock idle", adc_sclk, 1'b0);

        issue(8'h00, 1'b1);
        rd(2'd3, v); chk("R8 pending after frame", v[4], 1'b1);
        chk("R8 irq raised", irq, 1'b1);
        chk("R5 scoreboard drained", q_res.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule